// File: doc/BRIEF.md
# Multi-Mode I/O Port Register Bank

This block keeps the registers behind five 8-bit I/O ports. Each port has four views, chosen by a 2-bit selector: a legacy view, an output data byte, an output-enable mask and a sampled input byte. A core issues one register operation at a time over a valid/ready request channel. Each operation is a plain read, a full-byte write, or a read-modify-write that changes one bit. Every accepted operation gets a single-cycle response on the next cycle. The bank drives one output value and one enable per pin, and it samples the input pins through a two-flop synchronizer.

The legacy view gives old code the open-drain style port it expects. A mode input selects where writes to that view go. With the mode low, they land in the enable mask, so writing a 1 releases the pin to an external pull-up and writing a 0 drives it low. With the mode high, they land in the data byte, and software controls the mask directly. A plain read of the legacy view returns the pins. A read-modify-write returns the register the write will update, so single-bit operations do not corrupt the stored value.

Top module: `port_regbank`

## Requirements
- R1: After reset, every data byte is 0x00, and the enable masks of ports 0 to 3 are 0xFF. The enable mask of port 4 is 0x00. No response is pending, and the request channel is ready.
- R2: Pin 8*p+b drives bit b of port p's data byte on pin_out and bit b of its enable mask on pin_oen. An enable bit of 1 releases the pin.
- R3: With mode_bidir low, a write to selector 0 (legacy view) stores the byte in the enable mask and leaves the data byte unchanged. For example, writing 0x3F to port 0 releases pins 0 to 5 and drives pins 6 and 7 low.
- R4: With mode_bidir high, a write to selector 0 stores the byte in the data byte and leaves the enable mask unchanged.
- R5: A write to selector 1 updates the data byte and a write to selector 2 updates the enable mask, whatever the mode. A plain read of selector 1 or 2 returns that register.
- R6: A plain read of selector 0 or selector 3 returns the synchronized input byte of the port, in both modes. Any pin level held for at least two clock edges is visible to a read accepted after those edges.
- R7: A write or read-modify-write to selector 3 (input view) changes no register and no pin. A read-modify-write there returns the input byte.
- R8: A read-modify-write updates one target register. That target is the enable mask for selector 0 with the mode low, the data byte for selector 0 with the mode high, or the register named by selector 1 or 2. The response returns the old value of the target. The target is rewritten with bit req_bit_idx replaced by req_bit_val, and all other bits are kept.
- R9: req_ready is high only while idle. An accepted request (req_valid and req_ready) raises rsp_valid for exactly one cycle on the next cycle, and req_ready is low in that cycle. A full-byte write responds with data 0x00.
- R10: Port indices 5 to 7 address nothing. Reads there return 0x00, and writes there change no pin.
- R11: pin_out and pin_oen change only on the clock edge that accepts a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bank can accept a request |
| req_write | input | 1 | Full-byte write when set (and req_rmw clear) |
| req_rmw | input | 1 | Single-bit read-modify-write |
| req_port | input | 3 | Port index, 0 to 4 valid |
| req_sel | input | 2 | View: 0 legacy, 1 data, 2 enable mask, 3 input |
| req_wdata | input | 8 | Write byte |
| req_bit_idx | input | 3 | Bit position for read-modify-write |
| req_bit_val | input | 1 | New bit value for read-modify-write |
| mode_bidir | input | 1 | 0: legacy writes go to mask; 1: to data |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_data | output | 8 | Read value or old target value |
| pin_in | input | 40 | Raw pin levels, port p on bits 8p+7..8p |
| pin_out | output | 40 | Per-pin output value |
| pin_oen | output | 40 | Per-pin release (1) / drive (0) |

## Verification
The assertions assume that the request fields and mode_bidir hold steady while req_valid is high. They also assume req_rmw takes precedence over req_write. The bench drives every field at the falling edge, holds it through exactly one rising edge, and then drops req_valid, so each request is accepted once. Input pins change only while no request is in flight, and the bench waits three cycles before reading them. That keeps the synchronizer latency outside every expected value.

// File: rtl/port_regbank_pkg.sv
package port_regbank_pkg;

    typedef enum logic [1:0] {
        SEL_LEGACY = 2'd0,
        SEL_DATA   = 2'd1,
        SEL_OEN    = 2'd2,
        SEL_IN     = 2'd3
    } sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } bank_state_e;

endpackage

// File: rtl/pr_sync.sv
module pr_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q  <= '0;
            sync_out <= '0;
        end else begin
            stage_q  <= async_in;
            sync_out <= stage_q;
        end
    end
endmodule

// File: rtl/pr_port_slice.sv
module pr_port_slice #(
    parameter int               PORT_W  = 8,
    parameter logic [PORT_W-1:0] OEN_RST = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_data,
    input  logic              wr_oen,
    input  logic [PORT_W-1:0] new_val,
    output logic [PORT_W-1:0] data_q,
    output logic [PORT_W-1:0] oen_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            oen_q  <= OEN_RST;
        end else begin
            if (wr_data) data_q <= new_val;
            if (wr_oen)  oen_q  <= new_val;
        end
    end
endmodule

// File: rtl/pr_ctrl.sv
module pr_ctrl
    import port_regbank_pkg::*;
#(
    parameter int NUM_PORTS = 5,
    parameter int PORT_W    = 8,
    localparam int PIDX_W   = $clog2(NUM_PORTS),
    localparam int BIDX_W   = $clog2(PORT_W),
    localparam int VEC_W    = NUM_PORTS * PORT_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic                 req_rmw,
    input  logic [PIDX_W-1:0]    req_port,
    input  logic [1:0]           req_sel,
    input  logic [PORT_W-1:0]    req_wdata,
    input  logic [BIDX_W-1:0]    req_bit_idx,
    input  logic                 req_bit_val,
    input  logic                 mode_bidir,
    input  logic [VEC_W-1:0]     data_all,
    input  logic [VEC_W-1:0]     oen_all,
    input  logic [VEC_W-1:0]     in_all,
    output logic [NUM_PORTS-1:0] wr_data_en,
    output logic [NUM_PORTS-1:0] wr_oen_en,
    output logic [PORT_W-1:0]    wr_val,
    output logic                 rsp_valid,
    output logic [PORT_W-1:0]    rsp_data
);
    bank_state_e state_q, state_d;
    sel_e        sel;
    logic        accept, in_range, tgt_data, tgt_oen, do_update;
    int          pidx;
    logic [PORT_W-1:0] cur_data, cur_oen, cur_in, cur_tgt, modified, rd_val;

    assign sel       = sel_e'(req_sel);
    assign req_ready = (state_q == ST_IDLE);
    assign rsp_valid = (state_q == ST_RESP);
    assign accept    = req_valid && req_ready;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Port selection and view aliasing
    always_comb begin
        in_range = (req_port < PIDX_W'(NUM_PORTS));
        pidx     = in_range ? int'(req_port) : 0;
        cur_data = data_all[pidx*PORT_W +: PORT_W];
        cur_oen  = oen_all[pidx*PORT_W +: PORT_W];
        cur_in   = in_all[pidx*PORT_W +: PORT_W];
        tgt_data = 1'b0;
        tgt_oen  = 1'b0;
        unique case (sel)
            SEL_LEGACY: begin
                tgt_data = mode_bidir;
                tgt_oen  = !mode_bidir;
            end
            SEL_DATA: tgt_data = 1'b1;
            SEL_OEN:  tgt_oen  = 1'b1;
            SEL_IN:   ;
        endcase
        cur_tgt  = tgt_data ? cur_data : (tgt_oen ? cur_oen : cur_in);
        modified = cur_tgt;
        modified[req_bit_idx] = req_bit_val;
        wr_val    = req_rmw ? modified : req_wdata;
        do_update = accept && in_range && (req_write || req_rmw);
        wr_data_en = (do_update && tgt_data) ? (NUM_PORTS'(1) << req_port) : '0;
        wr_oen_en  = (do_update && tgt_oen)  ? (NUM_PORTS'(1) << req_port) : '0;

        rd_val = '0;
        if (in_range) begin
            if (req_rmw) begin
                rd_val = cur_tgt;
            end else if (!req_write) begin
                unique case (sel)
                    SEL_LEGACY, SEL_IN: rd_val = cur_in;
                    SEL_DATA:           rd_val = cur_data;
                    SEL_OEN:            rd_val = cur_oen;
                endcase
            end
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n)      rsp_data <= '0;
        else if (accept) rsp_data <= rd_val;
    end
endmodule

// File: rtl/port_regbank.sv
module port_regbank #(
    parameter int NUM_PORTS = 5,
    parameter int PORT_W    = 8,
    localparam int PIDX_W   = $clog2(NUM_PORTS),
    localparam int BIDX_W   = $clog2(PORT_W),
    localparam int VEC_W    = NUM_PORTS * PORT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_rmw,
    input  logic [PIDX_W-1:0] req_port,
    input  logic [1:0]        req_sel,
    input  logic [PORT_W-1:0] req_wdata,
    input  logic [BIDX_W-1:0] req_bit_idx,
    input  logic              req_bit_val,
    input  logic              mode_bidir,
    output logic              rsp_valid,
    output logic [PORT_W-1:0] rsp_data,
    input  logic [VEC_W-1:0]  pin_in,
    output logic [VEC_W-1:0]  pin_out,
    output logic [VEC_W-1:0]  pin_oen
);
    logic [VEC_W-1:0]     in_sync;
    logic [NUM_PORTS-1:0] wr_data_en, wr_oen_en;
    logic [PORT_W-1:0]    wr_val;

    pr_sync #(.W(VEC_W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (in_sync)
    );

    // The last port is internal and comes out of reset driving.
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        localparam logic [PORT_W-1:0] OEN_DEF =
            (p == NUM_PORTS - 1) ? {PORT_W{1'b0}} : {PORT_W{1'b1}};
        pr_port_slice #(.PORT_W(PORT_W), .OEN_RST(OEN_DEF)) u_slice (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_data (wr_data_en[p]),
            .wr_oen  (wr_oen_en[p]),
            .new_val (wr_val),
            .data_q  (pin_out[p*PORT_W +: PORT_W]),
            .oen_q   (pin_oen[p*PORT_W +: PORT_W])
        );
    end

    pr_ctrl #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_write   (req_write),
        .req_rmw     (req_rmw),
        .req_port    (req_port),
        .req_sel     (req_sel),
        .req_wdata   (req_wdata),
        .req_bit_idx (req_bit_idx),
        .req_bit_val (req_bit_val),
        .mode_bidir  (mode_bidir),
        .data_all    (pin_out),
        .oen_all     (pin_oen),
        .in_all      (in_sync),
        .wr_data_en  (wr_data_en),
        .wr_oen_en   (wr_oen_en),
        .wr_val      (wr_val),
        .rsp_valid   (rsp_valid),
        .rsp_data    (rsp_data)
    );
endmodule

// File: rtl/port_regbank_chk.sv
module port_regbank_chk #(
    parameter int NUM_PORTS = 5,
    parameter int PORT_W    = 8,
    localparam int PIDX_W   = $clog2(NUM_PORTS),
    localparam int VEC_W    = NUM_PORTS * PORT_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic              req_rmw,
    input logic [PIDX_W-1:0] req_port,
    input logic [1:0]        req_sel,
    input logic              mode_bidir,
    input logic              rsp_valid,
    input logic [PORT_W-1:0] rsp_data,
    input logic [VEC_W-1:0]  pin_out,
    input logic [VEC_W-1:0]  pin_oen
);
    logic acc, oor, full_wr;
    assign acc     = req_valid && req_ready;
    assign oor     = req_port >= PIDX_W'(NUM_PORTS);
    assign full_wr = req_write && !req_rmw;

    assert_rsp_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> rsp_valid);
    assert_busy_in_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);
    assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    assert_write_rsp_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && full_wr) |=> (rsp_data == '0));
    assert_pins_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> ($stable(pin_out) && $stable(pin_oen)));
    assert_in_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && (req_write || req_rmw) && req_sel == 2'd3)
        |=> ($stable(pin_out) && $stable(pin_oen)));
    assert_oor_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && oor && !req_write && !req_rmw) |=> (rsp_data == '0));
    assert_oor_no_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && oor) |=> ($stable(pin_out) && $stable(pin_oen)));
    assert_legacy_keeps_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && (req_write || req_rmw) && req_sel == 2'd0 && !mode_bidir)
        |=> $stable(pin_out));
    assert_legacy_keeps_oen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && (req_write || req_rmw) && req_sel == 2'd0 && mode_bidir)
        |=> $stable(pin_oen));
endmodule

bind port_regbank port_regbank_chk #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_rmw    (req_rmw),
    .req_port   (req_port),
    .req_sel    (req_sel),
    .mode_bidir (mode_bidir),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data),
    .pin_out    (pin_out),
    .pin_oen    (pin_oen)
);

// File: tb/port_regbank_bench.sv
module port_regbank_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 5;
    localparam int W  = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_rmw = 1'b0;
    logic        req_bit_val = 1'b0, mode_bidir = 1'b0;
    logic [2:0]  req_port = '0, req_bit_idx = '0;
    logic [1:0]  req_sel = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [7:0]  rsp_data;
    logic [39:0] pin_in = '0;
    logic [39:0] pin_out, pin_oen;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    logic [7:0] md [NP];
    logic [7:0] mo [NP];

    always #(CLK_PERIOD/2) clk = ~clk;

    port_regbank u_port_regbank (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_rmw(req_rmw), .req_port(req_port),
        .req_sel(req_sel), .req_wdata(req_wdata), .req_bit_idx(req_bit_idx),
        .req_bit_val(req_bit_val), .mode_bidir(mode_bidir), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .pin_in(pin_in), .pin_out(pin_out), .pin_oen(pin_oen)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_pins(input string tag);
        logic [39:0] eo, ee;
        for (int p = 0; p < NP; p++) begin
            eo[p*8 +: 8] = md[p];
            ee[p*8 +: 8] = mo[p];
        end
        chk({tag, " R2 pin_out"}, 64'(pin_out), 64'(eo));
        chk({tag, " R2 pin_oen"}, 64'(pin_oen), 64'(ee));
    endtask

    // Expected response and register update, from the requirements.
    task automatic model(input logic wr, input logic rmw, input int port, input int sel,
                         input logic [7:0] wd, input int bi, input logic bv,
                         output logic [7:0] exp);
        logic [7:0] inb, cur, nv;
        int tgt;
        exp = 8'h00;
        if (port >= NP) return;
        inb = pin_in[port*8 +: 8];
        if (!wr && !rmw) begin
            exp = (sel == 0 || sel == 3) ? inb : (sel == 1) ? md[port] : mo[port];
        end else begin
            tgt = (sel == 0) ? (mode_bidir ? 1 : 2) : sel;
            if (tgt == 3) begin
                exp = rmw ? inb : 8'h00;
            end else begin
                cur = (tgt == 1) ? md[port] : mo[port];
                exp = rmw ? cur : 8'h00;
                nv  = rmw ? ((cur & ~(8'h01 << bi)) | (8'(bv) << bi)) : wd;
                if (tgt == 1) md[port] = nv; else mo[port] = nv;
            end
        end
    endtask

    task automatic do_req(input string tag, input logic wr, input logic rmw,
                          input int port, input int sel, input logic [7:0] wd,
                          input int bi, input logic bv);
        logic [7:0] exp;
        model(wr, rmw, port, sel, wd, bi, bv, exp);
        @(negedge clk);
        chk({tag, " R9 ready idle"}, 64'(req_ready), 64'd1);
        req_valid = 1'b1; req_write = wr; req_rmw = rmw;
        req_port = 3'(port); req_sel = 2'(sel); req_wdata = wd;
        req_bit_idx = 3'(bi); req_bit_val = bv;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " R9 rsp_valid"}, 64'(rsp_valid), 64'd1);
        chk({tag, " R9 busy"}, 64'(req_ready), 64'd0);
        chk({tag, " rsp_data"}, 64'(rsp_data), 64'(exp));
        chk_pins({tag, " R11"});
        @(negedge clk);
        chk({tag, " R9 pulse end"}, 64'(rsp_valid), 64'd0);
    endtask

    task automatic set_pins(input logic [39:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        for (int p = 0; p < NP; p++) begin
            md[p] = 8'h00;
            mo[p] = (p == NP - 1) ? 8'h00 : 8'hFF;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 oen default", 64'(pin_oen), 64'h00_FFFFFFFF);
        chk("R1 data default", 64'(pin_out), 64'h0);
        chk("R1 rsp idle", 64'(rsp_valid), 64'd0);
        chk("R1 ready", 64'(req_ready), 64'd1);

        set_pins(40'hC3_5A_96_0F_E1);

        // R3 worked example: 0x3F in legacy mode on port 0
        mode_bidir = 1'b0;
        do_req("R3 example", 1'b1, 1'b0, 0, 0, 8'h3F, 0, 1'b0);
        chk("R3 example oen", 64'(pin_oen[7:0]), 64'h3F);
        chk("R3 example out", 64'(pin_out[7:0]), 64'h00);

        // R3 R4 R5 R7 R10 sweep: every mode, port index and view
        for (int m = 0; m < 2; m++) begin
            mode_bidir = m[0];
            for (int p = 0; p < 8; p++) begin
                for (int s = 0; s < 4; s++) begin
                    logic [7:0] wd;
                    wd = 8'((p * 37 + s * 11 + m * 90) ^ 8'hA5);
                    do_req(m ? "R4 R5 R7 R10 write" : "R3 R5 R7 R10 write",
                           1'b1, 1'b0, p, s, wd, 0, 1'b0);
                    do_req("R5 R6 R10 read", 1'b0, 1'b0, p, s, 8'h00, 0, 1'b0);
                end
            end
        end

        // R8 single-bit updates through every view
        for (int m = 0; m < 2; m++) begin
            mode_bidir = m[0];
            for (int p = 0; p < NP; p++) begin
                for (int b = 0; b < 8; b++) begin
                    do_req("R8 rmw legacy", 1'b0, 1'b1, p, 0, 8'h00, b, 1'((b + p + m) % 2));
                end
                do_req("R8 rmw data", 1'b0, 1'b1, p, 1, 8'h00, (p + 3) % 8, 1'b1);
                do_req("R8 rmw oen", 1'b0, 1'b1, p, 2, 8'h00, (p + 5) % 8, 1'b0);
                do_req("R7 rmw input", 1'b0, 1'b1, p, 3, 8'h00, p, 1'b1);
                // rmw takes priority over the write flag
                do_req("R8 rmw over write", 1'b1, 1'b1, p, 0, 8'hFF, 7 - p, 1'b0);
            end
        end

        // R6 new pin patterns read through legacy and input views in both modes
        for (int k = 0; k < 3; k++) begin
            set_pins(40'h1234567890 ^ (40'hFF_FFFF_FFFF >> (k * 7)));
            for (int m = 0; m < 2; m++) begin
                mode_bidir = m[0];
                for (int p = 0; p < NP; p++) begin
                    do_req("R6 legacy read", 1'b0, 1'b0, p, 0, 8'h00, 0, 1'b0);
                    do_req("R6 input read", 1'b0, 1'b0, p, 3, 8'h00, 0, 1'b0);
                end
            end
        end

        // R10 out-of-range read-modify-write
        do_req("R10 oor rmw", 1'b0, 1'b1, 6, 0, 8'h00, 2, 1'b1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule